// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits between a configuration-space request port and an on-chip fabric. Each request names a bus, a device, a function, a byte offset, an access size and a direction. The block performs four jobs for each request:

- It rejects device numbers that cannot exist behind the root port.
- It picks type-0 or type-1 configuration from the bus number.
- It reloads one outbound translation region with that type and a target identifier.
- It issues one or two word-aligned accesses to either the local root-port register window or the outbound configuration window.

Sub-word writes are done as read, merge and write back, because the fabric only moves whole words. Reads that are filtered or that fail downstream complete with all-ones data, so enumeration software sees an absent function instead of stale data.

One request is in flight at a time. The requester waits for `req_ready`, drives one cycle with `req_valid`, and later receives a single-cycle `rsp_valid`. The fabric side holds `dn_valid` and the request fields steady until `dn_ack`.

Top module: `cfgx_xlate`

## Requirements
- R1: A target is illegal when the bus is 0 and the device number is above 1, or when the bus is 1 and the device number is above 0. Every other combination is legal.
- R2: A read of an illegal target completes with `rsp_err`=0 and `rsp_rdata`=0xFFFFFFFF, and `dn_valid` never rises for it.
- R3: A write to an illegal target completes with `rsp_err`=1 and `rsp_rdata`=0, and makes no downstream access.
- R4: When a legal request is accepted, `rgn_type` becomes 4 if the bus is 0 or 1, and 5 for any higher bus. Illegal requests leave `rgn_type` and `rgn_target` unchanged. After reset, `rgn_type` is 4 and `rgn_target` is 0.
- R5: Bus 0 accesses use the local window (`dn_local`=1) and leave `rgn_target` unchanged. Any other bus uses the configuration window (`dn_local`=0) and loads `rgn_target` with bus in bits 31:24, device in 23:19, function in 18:16, and zeros below.
- R6: `dn_addr` equals the request offset with bits 1:0 cleared.
- R7: `req_size` encodes the access width: 0 is one byte at lane `off[1:0]`, 1 is two bytes at lanes starting at `2*off[1]` (`off[0]` ignored), and 2 or 3 is the full word. For a sub-word write, the block reads the word, replaces the selected lanes with the low-order bytes of `req_wdata`, and writes the result back.
- R8: A full-word write issues a single write access with no read phase.
- R9: A read of a legal target returns the whole aligned word from `dn_rdata` with `rsp_err`=0.
- R10: If a read phase is acknowledged with `dn_err`, the outcome depends on the request. For a read, the response is 0xFFFFFFFF with `rsp_err`=0. For a sub-word write, the response has `rsp_err`=1 and no write phase follows. A write phase acknowledged with `dn_err` gives `rsp_err`=1. All write responses carry `rsp_rdata`=0.
- R11: `req_ready` is high only while no request is in flight. Each accepted request yields exactly one single-cycle `rsp_valid`. After reset, `req_ready`=1 and both `rsp_valid` and `dn_valid` are 0.
- R12: While `dn_valid` is high and `dn_ack` is low, `dn_addr`, `dn_write`, `dn_local` and `dn_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_fn | input | 3 | Function number |
| req_off | input | 12 | Byte offset in configuration space |
| req_size | input | 2 | Access width code (see R7) |
| req_wdata | input | 32 | Right-aligned write data |
| rsp_valid | output | 1 | Single-cycle completion |
| rsp_err | output | 1 | Completion error flag |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| rgn_type | output | 3 | Translation region type code |
| rgn_target | output | 32 | Translation region target identifier |
| dn_valid | output | 1 | Fabric access pending |
| dn_write | output | 1 | Fabric access is a write |
| dn_local | output | 1 | 1 = local register window, 0 = configuration window |
| dn_addr | output | 12 | Word-aligned offset |
| dn_wdata | output | 32 | Fabric write data |
| dn_ack | input | 1 | Fabric completion |
| dn_err | input | 1 | Fabric completion carries an error |
| dn_rdata | input | 32 | Fabric read data |

## Verification
The risky overlap is between the fabric error path and the read-merge-write path. The same `dn_ack` edge that returns the old word for a sub-word write can also carry `dn_err`, and the block must then choose between merging and aborting. The bench provokes this by making its fabric model flag read-phase completions while a byte write is outstanding. It judges the outcome by a `rsp_err` of 1 and an unchanged write-access count, and it runs the same injection on a plain read, where all-ones data with no error is expected instead.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam logic [2:0] CFG_TYPE0 = 3'd4;
  localparam logic [2:0] CFG_TYPE1 = 3'd5;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RD   = 2'd1,
    SQ_WR   = 2'd2,
    SQ_RSP  = 2'd3
  } sq_e;
endpackage

// File: rtl/cfgx_filter.sv
module cfgx_filter
  import cfgx_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int FN_W   = 3,
  parameter int DATA_W = 32
) (
  input  logic [BUS_W-1:0]  bus,
  input  logic [DEV_W-1:0]  dev,
  input  logic [FN_W-1:0]   fn,
  output logic              ok,
  output logic              local_win,
  output logic [2:0]        cfg_type,
  output logic [DATA_W-1:0] target
);
  localparam int ID_W  = BUS_W + DEV_W + FN_W;
  localparam int PAD_W = DATA_W - ID_W;

  logic on_bus0, on_bus1;

  always_comb begin
    on_bus0   = (bus == BUS_W'(0));
    on_bus1   = (bus == BUS_W'(1));
    // root bus carries the port itself and one peer; first downstream bus one device
    ok        = !((on_bus0 && (dev > DEV_W'(1))) || (on_bus1 && (dev != DEV_W'(0))));
    local_win = on_bus0;
    cfg_type  = (on_bus0 || on_bus1) ? CFG_TYPE0 : CFG_TYPE1;
  end

  assign target = {bus, dev, fn, {PAD_W{1'b0}}};
endmodule

// File: rtl/cfgx_lane.sv
module cfgx_lane #(
  parameter int DATA_W = 32
) (
  input  logic [$clog2(DATA_W/8)-1:0] off_lo,
  input  logic [1:0]                  size,
  input  logic [DATA_W-1:0]           old_word,
  input  logic [DATA_W-1:0]           new_data,
  output logic [DATA_W-1:0]           merged
);
  localparam int NB = DATA_W / 8;
  localparam int LW = $clog2(NB);

  logic [LW-1:0]     base;
  logic [NB-1:0]     be;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    case (size)
      2'd0: begin
        base = off_lo;
        be   = NB'(1) << off_lo;
      end
      2'd1: begin
        base = {off_lo[LW-1:1], 1'b0};
        be   = NB'(3) << {off_lo[LW-1:1], 1'b0};
      end
      default: begin
        base = '0;
        be   = '1;
      end
    endcase
    shifted = new_data << {base, 3'b000};
  end

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign merged[i*8 +: 8] = be[i] ? shifted[i*8 +: 8] : old_word[i*8 +: 8];
  end
endmodule

// File: rtl/cfgx_region.sv
module cfgx_region
  import cfgx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_tgt,
  input  logic [2:0]        type_in,
  input  logic [DATA_W-1:0] tgt_in,
  output logic [2:0]        type_q,
  output logic [DATA_W-1:0] tgt_q
);
  logic tgt_en;

  assign tgt_en = load && load_tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= CFG_TYPE0;
    end else if (load) begin
      type_q <= type_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
    end else if (tgt_en) begin
      tgt_q <= tgt_in;
    end
  end
endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
  import cfgx_pkg::*;
#(
  parameter int OFF_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic                        req_ok,
  input  logic                        req_local,
  input  logic [OFF_W-1:0]            req_off,
  input  logic [1:0]                  req_size,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic                        req_ready,
  output logic                        accept,
  output logic                        dn_valid,
  output logic                        dn_write,
  output logic                        dn_local,
  output logic [OFF_W-1:0]            dn_addr,
  output logic [DATA_W-1:0]           dn_wdata,
  input  logic                        dn_ack,
  input  logic                        dn_err,
  input  logic [DATA_W-1:0]           dn_rdata,
  input  logic [DATA_W-1:0]           merged,
  output logic [$clog2(DATA_W/8)-1:0] off_lo,
  output logic [1:0]                  size_q,
  output logic                        rsp_valid,
  output logic                        rsp_err,
  output logic [DATA_W-1:0]           rsp_rdata
);
  localparam int LW = $clog2(DATA_W / 8);

  sq_e               st_q, st_d;
  logic              wr_q, loc_q;
  logic [OFF_W-1:0]  addr_q;
  logic [LW-1:0]     lo_q;
  logic [DATA_W-1:0] wbuf_q, wbuf_d;
  logic              wb_ld, wb_en, rsp_ld, err_d;
  logic [DATA_W-1:0] data_d;

  assign req_ready = (st_q == SQ_IDLE);
  assign accept    = req_valid && req_ready;

  // next-state and response selection
  always_comb begin
    st_d   = st_q;
    rsp_ld = 1'b0;
    wb_ld  = 1'b0;
    err_d  = 1'b0;
    data_d = '0;
    unique case (st_q)
      SQ_IDLE: if (req_valid) begin
        if (!req_ok) begin
          st_d   = SQ_RSP;
          rsp_ld = 1'b1;
          err_d  = req_write;
          data_d = req_write ? '0 : '1;
        end else if (req_write && req_size[1]) begin
          st_d = SQ_WR;
        end else begin
          st_d = SQ_RD;
        end
      end
      SQ_RD: if (dn_ack) begin
        if (dn_err) begin
          st_d   = SQ_RSP;
          rsp_ld = 1'b1;
          err_d  = wr_q;
          data_d = wr_q ? '0 : '1;
        end else if (wr_q) begin
          st_d  = SQ_WR;
          wb_ld = 1'b1;
        end else begin
          st_d   = SQ_RSP;
          rsp_ld = 1'b1;
          data_d = dn_rdata;
        end
      end
      SQ_WR: if (dn_ack) begin
        st_d   = SQ_RSP;
        rsp_ld = 1'b1;
        err_d  = dn_err;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  assign wb_en  = accept || wb_ld;
  assign wbuf_d = accept ? req_wdata : merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      loc_q  <= 1'b0;
      addr_q <= '0;
      lo_q   <= '0;
      size_q <= '0;
    end else if (accept) begin
      wr_q   <= req_write;
      loc_q  <= req_local;
      addr_q <= {req_off[OFF_W-1:2], 2'b00};
      lo_q   <= req_off[LW-1:0];
      size_q <= req_size;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wbuf_q <= '0;
    else if (wb_en) wbuf_q <= wbuf_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else if (rsp_ld) begin
      rsp_err   <= err_d;
      rsp_rdata <= data_d;
    end
  end

  assign dn_valid  = (st_q == SQ_RD) || (st_q == SQ_WR);
  assign dn_write  = (st_q == SQ_WR);
  assign dn_local  = loc_q;
  assign dn_addr   = addr_q;
  assign dn_wdata  = wbuf_q;
  assign off_lo    = lo_q;
  assign rsp_valid = (st_q == SQ_RSP);
endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate #(
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int FN_W   = 3,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FN_W-1:0]   req_fn,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [2:0]        rgn_type,
  output logic [DATA_W-1:0] rgn_target,
  output logic              dn_valid,
  output logic              dn_write,
  output logic              dn_local,
  output logic [OFF_W-1:0]  dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_ack,
  input  logic              dn_err,
  input  logic [DATA_W-1:0] dn_rdata
);
  localparam int LW = $clog2(DATA_W / 8);

  logic              f_ok, f_local, accept, rgn_load;
  logic [2:0]        f_type;
  logic [DATA_W-1:0] f_target, merged;
  logic [LW-1:0]     off_lo;
  logic [1:0]        size_q;

  cfgx_filter #(.BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .DATA_W(DATA_W)) u_filter (
    .bus(req_bus), .dev(req_dev), .fn(req_fn),
    .ok(f_ok), .local_win(f_local), .cfg_type(f_type), .target(f_target)
  );

  assign rgn_load = accept && f_ok;

  cfgx_region #(.DATA_W(DATA_W)) u_region (
    .clk(clk), .rst_n(rst_n), .load(rgn_load), .load_tgt(!f_local),
    .type_in(f_type), .tgt_in(f_target), .type_q(rgn_type), .tgt_q(rgn_target)
  );

  cfgx_lane #(.DATA_W(DATA_W)) u_lane (
    .off_lo(off_lo), .size(size_q), .old_word(dn_rdata), .new_data(dn_wdata), .merged(merged)
  );

  cfgx_seq #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_ok(f_ok), .req_local(f_local),
    .req_off(req_off), .req_size(req_size), .req_wdata(req_wdata),
    .req_ready(req_ready), .accept(accept),
    .dn_valid(dn_valid), .dn_write(dn_write), .dn_local(dn_local),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_ack(dn_ack), .dn_err(dn_err), .dn_rdata(dn_rdata), .merged(merged),
    .off_lo(off_lo), .size_q(size_q),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/cfgx_xlate_chk.sv
module cfgx_xlate_chk #(
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int FN_W   = 3,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [BUS_W-1:0]  req_bus,
  input logic [DEV_W-1:0]  req_dev,
  input logic [1:0]        req_size,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [2:0]        rgn_type,
  input logic              dn_valid,
  input logic              dn_write,
  input logic              dn_local,
  input logic [OFF_W-1:0]  dn_addr,
  input logic [DATA_W-1:0] dn_wdata,
  input logic              dn_ack,
  input logic              dn_err
);
  logic acc;
  assign acc = req_valid && req_ready;

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!dn_valid && !rsp_valid));

  a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r12_dn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ack) |=> (dn_valid && $stable(dn_addr) && $stable(dn_write)
                               && $stable(dn_local) && $stable(dn_wdata)));

  a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (dn_addr[1:0] == 2'b00));

  a_r3_bad_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && (req_bus == BUS_W'(1)) && (req_dev != DEV_W'(0)))
      |=> (rsp_valid && rsp_err && !dn_valid));

  a_r2_bad_read: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && (req_bus == BUS_W'(0)) && (req_dev > DEV_W'(1)))
      |=> (rsp_valid && !rsp_err && (rsp_rdata == '1) && !dn_valid));

  a_r10_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_write && dn_ack && dn_err) |=> !dn_valid);

  a_r8_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && (req_size >= 2'd2) && (req_bus > BUS_W'(1))) |=> (dn_valid && dn_write));

  a_r4_far_type: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (req_bus > BUS_W'(1))) |=> (rgn_type == 3'd5));
endmodule

bind cfgx_xlate cfgx_xlate_chk #(
  .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/cfgx_xlate_tb.sv
module cfgx_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [7:0]  req_bus;
  logic [4:0]  req_dev;
  logic [2:0]  req_fn;
  logic [11:0] req_off;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [2:0]  rgn_type;
  logic [31:0] rgn_target;
  logic        dn_valid, dn_write, dn_local;
  logic [11:0] dn_addr;
  logic [31:0] dn_wdata;
  logic        dn_ack, dn_err;
  logic [31:0] dn_rdata;

  always #4 clk = ~clk;

  cfgx_xlate u_dut (.*);

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // fabric model
  logic [31:0] mem [32];
  int          lat = 1;
  logic        err_rd = 1'b0, err_wr = 1'b0;
  int          n_rd = 0, n_wr = 0, n_seen = 0;
  logic [11:0] last_addr;
  logic        last_local;

  initial begin
    int wcnt;
    wcnt = 0;
    dn_ack = 1'b0; dn_err = 1'b0; dn_rdata = '0;
    last_addr = '0; last_local = 1'b0;
    for (int i = 0; i < 32; i++) mem[i] = 32'h11223300 | i;
    forever begin
      @(negedge clk);
      if (dn_valid) n_seen++;
      if (dn_valid && !dn_ack && wcnt >= lat) begin
        dn_ack     = 1'b1;
        dn_err     = dn_write ? err_wr : err_rd;
        dn_rdata   = mem[{dn_local, dn_addr[5:2]}];
        last_addr  = dn_addr;
        last_local = dn_local;
        if (dn_write) begin
          n_wr++;
          if (!err_wr) mem[{dn_local, dn_addr[5:2]}] = dn_wdata;
        end else begin
          n_rd++;
        end
      end else begin
        if (dn_ack) wcnt = 0;
        else if (dn_valid) wcnt++;
        dn_ack = 1'b0;
        dn_err = 1'b0;
      end
    end
  end

  logic        got_err;
  logic [31:0] got_data;

  task automatic do_req(input logic wr, input logic [7:0] bus, input logic [4:0] dev,
                        input logic [2:0] fn, input logic [11:0] off, input logic [1:0] size,
                        input logic [31:0] wd, input logic chk_busy);
    int t;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_bus = bus; req_dev = dev;
    req_fn = fn; req_off = off; req_size = size; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (chk_busy && !rsp_valid) check("R11 ready low while busy", {31'b0, req_ready}, 32'd0);
    t = 0;
    while (!rsp_valid && t < 200) begin
      @(negedge clk);
      t++;
    end
    if (!rsp_valid) check("R11 response timeout", 32'd0, 32'd1);
    got_err  = rsp_err;
    got_data = rsp_rdata;
    @(negedge clk);
    check("R11 single response pulse", {31'b0, rsp_valid}, 32'd0);
  endtask

  typedef struct packed {
    logic        wr;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [11:0] off;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic        exp_err;
    logic [31:0] exp_data;
    logic [2:0]  exp_type;
    logic [31:0] exp_tgt;
    logic [1:0]  acc;
    logic        exp_local;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b0, 8'd0, 5'd0,  3'd0, 12'h008, 2'd0 + 2'd2, 32'h0,        1'b0, 32'h11223312, 3'd4, 32'h00000000, 2'd1, 1'b1},
    '{1'b0, 8'd1, 5'd0,  3'd2, 12'h010, 2'd2,        32'h0,        1'b0, 32'h11223304, 3'd4, 32'h01020000, 2'd1, 1'b0},
    '{1'b0, 8'd3, 5'd7,  3'd1, 12'h00C, 2'd2,        32'h0,        1'b0, 32'h11223303, 3'd5, 32'h03390000, 2'd1, 1'b0},
    '{1'b0, 8'd0, 5'd2,  3'd0, 12'h000, 2'd2,        32'h0,        1'b0, 32'hFFFFFFFF, 3'd5, 32'h03390000, 2'd0, 1'b0},
    '{1'b1, 8'd1, 5'd1,  3'd0, 12'h000, 2'd2,        32'h55,       1'b1, 32'h00000000, 3'd5, 32'h03390000, 2'd0, 1'b0},
    '{1'b1, 8'd2, 5'd0,  3'd0, 12'h014, 2'd2,        32'hDEADBEEF, 1'b0, 32'h00000000, 3'd5, 32'h02000000, 2'd1, 1'b0},
    '{1'b1, 8'd2, 5'd0,  3'd0, 12'h017, 2'd0,        32'h000000AA, 1'b0, 32'h00000000, 3'd5, 32'h02000000, 2'd2, 1'b0},
    '{1'b0, 8'd2, 5'd0,  3'd0, 12'h015, 2'd0,        32'h0,        1'b0, 32'hAAADBEEF, 3'd5, 32'h02000000, 2'd1, 1'b0},
    '{1'b1, 8'd0, 5'd1,  3'd0, 12'h021, 2'd1,        32'h00001234, 1'b0, 32'h00000000, 3'd4, 32'h02000000, 2'd2, 1'b1},
    '{1'b0, 8'd0, 5'd1,  3'd0, 12'h022, 2'd2,        32'h0,        1'b0, 32'h11221234, 3'd4, 32'h02000000, 2'd1, 1'b1},
    '{1'b1, 8'd5, 5'd31, 3'd7, 12'h006, 2'd1,        32'hFFFF5678, 1'b0, 32'h00000000, 3'd5, 32'h05FF0000, 2'd2, 1'b0},
    '{1'b0, 8'd5, 5'd31, 3'd7, 12'h004, 2'd2,        32'h0,        1'b0, 32'h56783301, 3'd5, 32'h05FF0000, 2'd1, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int rd0, wr0, seen0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_bus = '0; req_dev = '0;
    req_fn = '0; req_off = '0; req_size = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset req_ready", {31'b0, req_ready}, 32'd1);
    check("R11 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R11 reset dn_valid", {31'b0, dn_valid}, 32'd0);
    check("R4 reset rgn_type", {29'b0, rgn_type}, 32'd4);
    check("R4 reset rgn_target", rgn_target, 32'd0);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R9
    lat = 2;
    for (int i = 0; i < 12; i++) begin
      rd0 = n_rd; wr0 = n_wr; seen0 = n_seen;
      do_req(VEC[i].wr, VEC[i].bus, VEC[i].dev, VEC[i].fn, VEC[i].off, VEC[i].size, VEC[i].wdata, 1'b1);
      check($sformatf("R2 R3 R10 vec%0d rsp_err", i), {31'b0, got_err}, {31'b0, VEC[i].exp_err});
      check($sformatf("R7 R9 vec%0d rsp_rdata", i), got_data, VEC[i].exp_data);
      check($sformatf("R4 vec%0d rgn_type", i), {29'b0, rgn_type}, {29'b0, VEC[i].exp_type});
      check($sformatf("R5 vec%0d rgn_target", i), rgn_target, VEC[i].exp_tgt);
      check($sformatf("R1 vec%0d access count", i), n_rd + n_wr - rd0 - wr0, {30'b0, VEC[i].acc});
      if (VEC[i].acc == 2'd0)
        check($sformatf("R1 vec%0d dn_valid never seen", i), n_seen - seen0, 32'd0);
      else begin
        check($sformatf("R5 vec%0d window", i), {31'b0, last_local}, {31'b0, VEC[i].exp_local});
        check($sformatf("R6 vec%0d aligned addr", i), {20'b0, last_addr}, {20'b0, VEC[i].off & 12'hFFC});
      end
    end

    lat = 0;
    // R8: size 3 full write, no read phase
    rd0 = n_rd; wr0 = n_wr;
    do_req(1'b1, 8'd4, 5'd3, 3'd0, 12'h008, 2'd3, 32'hCAFEF00D, 1'b0);
    check("R8 no read phase", n_rd - rd0, 32'd0);
    check("R8 one write phase", n_wr - wr0, 32'd1);
    check("R8 write data stored", mem[2], 32'hCAFEF00D);

    // R10: read-phase error on plain read
    err_rd = 1'b1;
    do_req(1'b0, 8'd2, 5'd0, 3'd0, 12'h030, 2'd2, 32'h0, 1'b0);
    check("R10 read error data", got_data, 32'hFFFFFFFF);
    check("R10 read error flag", {31'b0, got_err}, 32'd0);

    // R10: read-phase error during sub-word write
    wr0 = n_wr;
    do_req(1'b1, 8'd2, 5'd0, 3'd0, 12'h031, 2'd0, 32'h77, 1'b0);
    check("R10 merge abort flag", {31'b0, got_err}, 32'd1);
    check("R10 merge abort no write", n_wr - wr0, 32'd0);
    err_rd = 1'b0;
    do_req(1'b0, 8'd2, 5'd0, 3'd0, 12'h030, 2'd2, 32'h0, 1'b0);
    check("R10 word untouched after abort", got_data, 32'h1122330C);

    // R10: write-phase error
    err_wr = 1'b1;
    do_req(1'b1, 8'd6, 5'd0, 3'd0, 12'h03C, 2'd2, 32'h0BADBAD0, 1'b0);
    check("R10 write error flag", {31'b0, got_err}, 32'd1);
    check("R10 write error data", got_data, 32'd0);
    err_wr = 1'b0;

    // R7: halfword with offset bit 0 ignored, lanes 0..1
    do_req(1'b1, 8'd9, 5'd0, 3'd0, 12'h025, 2'd1, 32'h0000ABCD, 1'b0);
    do_req(1'b0, 8'd9, 5'd0, 3'd0, 12'h024, 2'd2, 32'h0, 1'b0);
    check("R7 halfword lanes 0-1", got_data, 32'h1122ABCD);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule